// File: doc/BRIEF.md
# Post-Reset Power-Down Watchdog Counter

This block is a small safety timer that guards the early boot window of a chip. It is armed by reset itself. From the moment reset is released, it counts ticks of a low-frequency reference. Software never has to start it. If software does not disarm it before a fixed number of ticks has elapsed, the block pulls an active-low watchdog output low. That output stays low until the next reset. Its purpose is to recover a system whose cores hang before the main watchdog has been set up.

Software disarms the timer through one 16-bit control register at byte offset 0x08. The register is reached over a small request/response port with valid/ready handshakes. An accepted request is a read or a write, and each one returns exactly one response beat. The request side is back-pressured: `req_ready` is high only when the response slot is empty, or when its current beat is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data holds steady and no new request is accepted. Bit 0 of the register is the arm flag. Writing it as 0 disarms the timer and freezes the count. Writing it as 1 can never re-arm the timer; only reset does that.

With the default 32.768 kHz reference, the default tick limit of 524288 gives a 16-second window. A smaller value can be set for simulation.

Top module: `pwrdn_wdog`

## Requirements
- R1: After reset, `wdog_n_o` is 1, the register at offset 0x08 reads 0x0001 (arm flag set), and the timer counts `ref_tick` pulses without any software access.
- R2: With the arm flag set, `wdog_n_o` goes low in the cycle after the TICKS-th `ref_tick` pulse since reset, and not after any earlier pulse.
- R3: Once `wdog_n_o` is low, it stays low until reset, even if the arm flag is cleared afterwards.
- R4: An accepted write to offset 0x08 with bit 0 = 0 clears the arm flag. The count then freezes, and `wdog_n_o` never goes low in that reset period.
- R5: An accepted write to offset 0x08 with bit 0 = 1 never sets a cleared arm flag. While the flag is set, such a write does not disturb the count.
- R6: A read of offset 0x08 returns the arm flag in bit 0, with bits 15:1 zero. A read of any other offset returns 0x0000.
- R7: Reads and writes at any offset other than 0x08 change neither the arm flag nor the count.
- R8: A clearing write accepted in the same cycle as the terminal `ref_tick` pulse wins, so `wdog_n_o` does not go low.
- R9: A request transfers when `req_valid` and `req_ready` are both high. Each transfer yields one response beat on the next cycle. `req_ready` is low while a response is pending and `rsp_ready` is low, and during that time `rsp_rdata` holds stable.
- R10: Reset re-arms the flag and restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| ref_tick | input | 1 | One-cycle pulse per low-frequency reference period |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset within the watchdog register space |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response beat taken |
| rsp_rdata | output | 16 | Read data (0x0000 for writes and unmapped offsets) |
| wdog_n_o | output | 1 | Active-low watchdog output |

## Verification
The hardest case to reach is R8: a clearing write that lands in exactly the cycle of the terminal tick. The bench first issues TICKS-1 reference pulses. It then drives the final `ref_tick` pulse in the same cycle as the write request, with the response side free so the write is accepted on that edge. Back-pressure is reached by holding `rsp_ready` low after a read. A second request, a clearing write, is then left pending for several cycles. A read made after release confirms that the write took effect only when it was finally accepted.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  localparam int REG_DW      = 16;
  localparam int BUS_AW      = 8;
  localparam int ARM_BIT     = 0;
  localparam logic [BUS_AW-1:0] CTRL_OFFSET = 8'h08;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  function automatic logic [REG_DW-1:0] pack_ctrl(input logic arm);
    logic [REG_DW-1:0] v;
    v = '0;
    v[ARM_BIT] = arm;
    return v;
  endfunction
endpackage

// File: rtl/pwd_bus_port.sv
module pwd_bus_port
  import pwd_pkg::*;
#(
  parameter int AW = BUS_AW,
  parameter int DW = REG_DW,
  parameter logic [AW-1:0] OFFSET = CTRL_OFFSET
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  input  logic          arm_i,
  output logic          clear_o
);
  acc_kind_e kind;
  logic      hit;
  logic      slot_busy;
  logic [DW-1:0] rd_next;

  assign slot_busy = rsp_valid && !rsp_ready;
  assign req_ready = !slot_busy;
  assign hit       = (req_addr == OFFSET);

  always_comb begin
    kind = ACC_NONE;
    if (req_valid && req_ready) kind = req_write ? ACC_WRITE : ACC_READ;
  end

  assign clear_o = (kind == ACC_WRITE) && hit && !req_wdata[ARM_BIT];

  always_comb begin
    rd_next = '0;
    if (kind == ACC_READ && hit) rd_next = pack_ctrl(arm_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (kind != ACC_NONE) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pwd_arm_flag.sv
module pwd_arm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic arm_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)       arm_o <= 1'b1;
    else if (clear_i) arm_o <= 1'b0;
  end
endmodule

// File: rtl/pwd_tick_counter.sv
module pwd_tick_counter #(
  parameter int TICKS = 524288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic run_i,
  output logic fired_o
);
  localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic advance, at_last;

  assign advance = ref_tick && run_i && !fired_o;
  assign at_last = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      fired_o <= 1'b0;
    end else if (advance) begin
      if (at_last) fired_o <= 1'b1;
      else         cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwrdn_wdog.sv
module pwrdn_wdog
  import pwd_pkg::*;
#(
  parameter int TICKS = 524288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BUS_AW-1:0] req_addr,
  input  logic [REG_DW-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [REG_DW-1:0] rsp_rdata,
  output logic              wdog_n_o
);
  logic arm, clear, fired, run;

  pwd_bus_port #(.AW(BUS_AW), .DW(REG_DW), .OFFSET(CTRL_OFFSET)) u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .arm_i(arm), .clear_o(clear)
  );

  pwd_arm_flag u_flag (.clk(clk), .rst_n(rst_n), .clear_i(clear), .arm_o(arm));

  // a clear in flight this cycle beats the terminal tick (R8)
  assign run = arm && !clear;

  pwd_tick_counter #(.TICKS(TICKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run_i(run), .fired_o(fired)
  );

  assign wdog_n_o = !fired;
endmodule

// File: rtl/pwrdn_wdog_chk.sv
module pwrdn_wdog_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ref_tick,
  input logic        arm,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [15:0] rsp_rdata,
  input logic        wdog_n_o
);
  assert_out_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_n_o |=> !wdog_n_o);

  assert_arm_no_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !arm);

  assert_fire_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_n_o) |-> $past(ref_tick && arm));

  assert_disarmed_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && wdog_n_o) |=> wdog_n_o);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_rdata[15:1] == 15'd0));
endmodule

bind pwrdn_wdog pwrdn_wdog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .arm(arm),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_rdata(rsp_rdata), .wdog_n_o(wdog_n_o)
);

// File: tb/tb_pwrdn_wdog.sv
module tb_pwrdn_wdog;
  localparam int TC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [7:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, wdog_n_o;
  logic [15:0] rsp_rdata;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwrdn_wdog #(.TICKS(TC)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .wdog_n_o(wdog_n_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ref_tick = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ref_tick = 1'b1;
      @(negedge clk) ref_tick = 1'b0;
    end
  endtask

  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [15:0] wd,
                        input logic tk, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; ref_tick = tk;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; ref_tick = 1'b0;
    rd = rsp_rdata;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [15:0] rd);
    bus_op(1'b0, a, 16'h0, 1'b0, rd);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [15:0] wd);
    logic [15:0] dummy;
    bus_op(1'b1, a, wd, 1'b0, dummy);
  endtask

  task automatic t_reset_state();
    logic [15:0] r;
    do_reset();
    @(negedge clk);
    check("R1 out high", {15'd0, wdog_n_o}, 16'd1);
    check("R9 ready idle", {15'd0, req_ready}, 16'd1);
    check("R9 no rsp", {15'd0, rsp_valid}, 16'd0);
    rd_reg(8'h08, r);
    check("R1 R6 arm reads 1", r, 16'h0001);
  endtask

  task automatic t_timeout();
    do_reset();
    ticks(TC - 1);
    check("R2 not before last", {15'd0, wdog_n_o}, 16'd1);
    ticks(1);
    check("R2 fires on last", {15'd0, wdog_n_o}, 16'd0);
  endtask

  task automatic t_sticky_after_fire();
    logic [15:0] r;
    wr_reg(8'h08, 16'h0000);
    ticks(3);
    check("R3 stays low", {15'd0, wdog_n_o}, 16'd0);
    rd_reg(8'h08, r);
    check("R3 arm cleared late", r, 16'h0000);
  endtask

  task automatic t_clear_early();
    logic [15:0] r;
    do_reset();
    ticks(5);
    wr_reg(8'h08, 16'h0000);
    ticks(2 * TC);
    check("R4 never fires", {15'd0, wdog_n_o}, 16'd1);
    rd_reg(8'h08, r);
    check("R4 arm cleared", r, 16'h0000);
    wr_reg(8'h08, 16'hFFFF);
    rd_reg(8'h08, r);
    check("R5 no re-arm", r, 16'h0000);
    ticks(TC);
    check("R5 still quiet", {15'd0, wdog_n_o}, 16'd1);
  endtask

  task automatic t_set_write_harmless();
    logic [15:0] r;
    do_reset();
    ticks(7);
    wr_reg(8'h08, 16'hFFFF);
    rd_reg(8'h08, r);
    check("R5 arm stays set", r, 16'h0001);
    ticks(TC - 8);
    check("R5 count intact pre", {15'd0, wdog_n_o}, 16'd1);
    ticks(1);
    check("R5 count intact fire", {15'd0, wdog_n_o}, 16'd0);
  endtask

  task automatic t_other_offsets();
    logic [15:0] r;
    do_reset();
    wr_reg(8'h0A, 16'h0000);
    wr_reg(8'h00, 16'h0000);
    wr_reg(8'h09, 16'h0000);
    rd_reg(8'h0A, r);
    check("R6 unmapped reads 0", r, 16'h0000);
    rd_reg(8'h08, r);
    check("R7 arm untouched", r, 16'h0001);
    ticks(TC - 1);
    check("R7 count untouched pre", {15'd0, wdog_n_o}, 16'd1);
    ticks(1);
    check("R7 count untouched fire", {15'd0, wdog_n_o}, 16'd0);
  endtask

  task automatic t_race();
    logic [15:0] r;
    do_reset();
    ticks(TC - 1);
    bus_op(1'b1, 8'h08, 16'h0000, 1'b1, r);
    check("R8 clear wins", {15'd0, wdog_n_o}, 16'd1);
    ticks(TC);
    check("R8 stays quiet", {15'd0, wdog_n_o}, 16'd1);
  endtask

  task automatic t_backpressure();
    logic [15:0] r;
    do_reset();
    @(negedge clk); rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 8'h08;
    @(negedge clk);
    req_write = 1'b1; req_wdata = 16'h0000;
    repeat (3) @(negedge clk);
    check("R9 ready low", {15'd0, req_ready}, 16'd0);
    check("R9 rsp held", {15'd0, rsp_valid}, 16'd1);
    check("R9 data held", rsp_rdata, 16'h0001);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd_reg(8'h08, r);
    check("R9 held write applied", r, 16'h0000);
  endtask

  task automatic t_rearm();
    logic [15:0] r;
    do_reset();
    rd_reg(8'h08, r);
    check("R10 re-armed", r, 16'h0001);
    ticks(TC);
    check("R10 fires after full count", {15'd0, wdog_n_o}, 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_timeout();
    t_sticky_after_fire();
    t_clear_early();
    t_set_write_harmless();
    t_other_offsets();
    t_race();
    t_backpressure();
    t_rearm();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule